// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central scheduling controller for a small floating-point pipeline. It takes in one decoded instruction per cycle. Each instruction carries an operation class, a destination register and two source registers. The controller tracks four functional units: one adder, two multipliers and one divider. Instructions issue in program order. Each unit then reads its operands, runs for its own latency and writes its result back, and the units do these steps independently and out of order.

The controller produces only control events. The datapath watches these events to know when it may read the register file, when a result is ready and when a result may be written back:

- a one-cycle operand-read grant for each unit,
- a one-cycle execution-complete pulse for each unit,
- a one-cycle write-back enable for each unit.

The controller does no arithmetic and has no forwarding path. A dependent instruction reads its source only after the producing unit has written that register back.

The instruction input is a valid/ready stream. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the sender must hold the instruction fields stable. `in_ready` may change while `in_valid` is low, and it never depends on `in_valid`. `issue_stall` is the plain status form of the same back-pressure: it is high when an offered instruction is refused.

Top module: `fpu_hazard_board`

## Requirements
- R1: After reset, no unit is busy and no register has a pending write. No read grant, completion pulse or write-back enable is asserted. An add instruction offered to any register is ready.
- R2: Class codes select the unit. Code 0 goes to the adder (unit 0). Code 1 goes to the lowest-numbered free multiplier (unit 1, then unit 2). Code 2 goes to the divider (unit 3). Code 3 has no unit, so it is never accepted. At most one instruction is accepted per cycle.
- R3: While every unit of the offered class is busy, `in_ready` is low and `issue_stall` is high. A unit becomes free in the cycle after its write-back enable.
- R4: While a register has a pending write, an instruction with that register as destination is held back. The hold lasts until the cycle after the pending writer's write-back enable (WAW).
- R5: A unit's read grant lasts exactly one cycle. The earliest read grant is in the cycle after issue. A read grant is given only once no source has an outstanding producer. A source written by another unit becomes readable in the cycle after that unit's write-back enable.
- R6: A unit's completion pulse comes exactly L cycles after its read grant, where L is the latency parameter for that unit's class.
- R7: A unit's write-back enable comes no earlier than the cycle after its completion pulse. After write-back, the unit returns to free and its destination's pending status clears.
- R8: A unit's write-back is held while another unit still has a ready, unread source naming the same register as its destination (WAR).
- R9: At most one write-back enable is high in any cycle. When several units may write back in the same cycle, the lowest-numbered unit wins and the others retry in later cycles.
- R10: An instruction can issue in the same cycle that its source's producer writes back. That source then counts as ready, and the read grant follows in the next cycle.
- R11: A unit's `fu_busy` bit is high from the cycle after issue through its write-back cycle. A register's `reg_pend` bit is high from the cycle after issue until the cycle after write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction can be accepted this cycle |
| in_cls | input | 2 | Operation class: 0 add, 1 multiply, 2 divide, 3 none |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register |
| issue_stall | output | 1 | An offered instruction is refused |
| rd_grant | output | 4 | Per-unit operand-read grant |
| ex_done | output | 4 | Per-unit execution-complete pulse |
| wb_en | output | 4 | Per-unit write-back enable |
| fu_busy | output | 4 | Per-unit busy status |
| reg_pend | output | NREG | Per-register pending-write status |

## Verification
The hardest case to reach is the WAR hold. It needs a unit whose first source is ready but which cannot read yet because its second source is still waiting. At the same time, a faster unit must finish writing the register that the first source names. The stimulus issues three instructions back to back:

1. A multiply.
2. An add that reads an idle register and the multiply's result.
3. A short divide that writes the add's idle source.

The divide finishes first, and it must wait until the add has read. The same-cycle case for R10 is also hard to reach. The stimulus counts cycles from a divide's issue and offers the dependent add in exactly the cycle of the divide's write-back.

// File: rtl/hzb_pkg.sv
package hzb_pkg;
  localparam int NU  = 4;
  localparam int IDW = $clog2(NU + 1);

  typedef logic [IDW-1:0] fu_id_t;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_DIV  = 2'd2,
    CLS_NONE = 2'd3
  } op_cls_t;

  localparam op_cls_t UNIT_CLS [NU] = '{CLS_ADD, CLS_MUL, CLS_MUL, CLS_DIV};

  function automatic fu_id_t unit_id(input int u);
    return fu_id_t'(u + 1);
  endfunction
endpackage

// File: rtl/hzb_regtab.sv
module hzb_regtab #(
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            set_en,
  input  logic [RW-1:0]                   set_reg,
  input  hzb_pkg::fu_id_t                 set_id,
  input  logic                            clr_en,
  input  logic [RW-1:0]                   clr_reg,
  input  hzb_pkg::fu_id_t                 clr_id,
  output logic [NREG-1:0][hzb_pkg::IDW-1:0] pend_id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_id <= '0;
    end else begin
      if (clr_en) pend_id[clr_reg] <= '0;
      if (set_en) pend_id[set_reg] <= set_id;
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> pend_id[set_reg] == '0);  // R4

  AST_CLEAR_BY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pend_id[clr_reg] == clr_id);  // R7
endmodule

// File: rtl/hzb_unit.sv
module hzb_unit #(
  parameter int LAT = 2,
  parameter int RW  = 3,
  parameter int CW  = $clog2(LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [RW-1:0]   iss_fi,
  input  logic [RW-1:0]   iss_fj,
  input  logic [RW-1:0]   iss_fk,
  input  hzb_pkg::fu_id_t iss_qj,
  input  hzb_pkg::fu_id_t iss_qk,
  input  hzb_pkg::fu_id_t bc_id,
  input  logic            wb_grant,
  output logic            busy,
  output logic [RW-1:0]   fi,
  output logic [RW-1:0]   fj,
  output logic [RW-1:0]   fk,
  output logic            rj,
  output logic            rk,
  output logic            rd_grant,
  output logic            ex_done,
  output logic            wb_req
);
  typedef enum logic [1:0] {PH_IDLE, PH_OPS, PH_EXEC, PH_WB} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  hzb_pkg::fu_id_t qj, qk;

  assign busy     = (phase != PH_IDLE);
  assign rd_grant = (phase == PH_OPS) && rj && rk;
  assign ex_done  = (phase == PH_EXEC) && (cnt == '0);
  assign wb_req   = (phase == PH_WB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      fi    <= '0;
      fj    <= '0;
      fk    <= '0;
      qj    <= '0;
      qk    <= '0;
      rj    <= 1'b0;
      rk    <= 1'b0;
    end else if (issue) begin
      phase <= PH_OPS;
      fi    <= iss_fi;
      fj    <= iss_fj;
      fk    <= iss_fk;
      qj    <= iss_qj;
      qk    <= iss_qk;
      rj    <= (iss_qj == '0);
      rk    <= (iss_qk == '0);
    end else begin
      unique case (phase)
        PH_OPS: begin
          if (rd_grant) begin
            rj    <= 1'b0;
            rk    <= 1'b0;
            cnt   <= CW'(LAT - 1);
            phase <= PH_EXEC;
          end else begin
            if (qj != '0 && qj == bc_id) begin
              rj <= 1'b1;
              qj <= '0;
            end
            if (qk != '0 && qk == bc_id) begin
              rk <= 1'b1;
              qk <= '0;
            end
          end
        end
        PH_EXEC: begin
          if (cnt == '0) phase <= PH_WB;
          else           cnt   <= cnt - 1'b1;
        end
        PH_WB:   if (wb_grant) phase <= PH_IDLE;
        default: ;
      endcase
    end
  end

  AST_ISSUE_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> phase == PH_IDLE);  // R3

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> !rd_grant);  // R5

  AST_GRANT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_grant |-> phase == PH_WB);  // R7
endmodule

// File: rtl/hzb_wb_arb.sv
module hzb_wb_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && grant == '0) grant[i] = 1'b1;
    end
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R9

  AST_WB_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);  // R9
endmodule

// File: rtl/fpu_hazard_board.sv
module fpu_hazard_board #(
  parameter int NREG    = 8,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_cls,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src1,
  input  logic [$clog2(NREG)-1:0] in_src2,
  output logic                    issue_stall,
  output logic [hzb_pkg::NU-1:0]  rd_grant,
  output logic [hzb_pkg::NU-1:0]  ex_done,
  output logic [hzb_pkg::NU-1:0]  wb_en,
  output logic [hzb_pkg::NU-1:0]  fu_busy,
  output logic [NREG-1:0]         reg_pend
);
  import hzb_pkg::*;

  localparam int RW   = $clog2(NREG);
  localparam int LMAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                            : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
  localparam int CW   = $clog2(LMAX + 1);

  logic [NREG-1:0][IDW-1:0] pend_id;
  logic [NU-1:0][RW-1:0]    fi_a, fj_a, fk_a;
  logic [NU-1:0]            rj_a, rk_a, wb_req, war_ok, sel, issue_u;
  logic                     found, issue_fire, waw;
  fu_id_t                   sel_id, bc_id, qj_raw, qk_raw, iss_qj, iss_qk;
  logic [RW-1:0]            wb_reg;

  // unit selection: lowest free unit of the offered class
  always_comb begin
    sel    = '0;
    found  = 1'b0;
    sel_id = '0;
    for (int u = 0; u < NU; u++) begin
      if (!found && UNIT_CLS[u] == op_cls_t'(in_cls) && !fu_busy[u]) begin
        sel[u] = 1'b1;
        found  = 1'b1;
        sel_id = unit_id(u);
      end
    end
  end

  assign waw         = (pend_id[in_dst] != '0);
  assign in_ready    = found && !waw;
  assign issue_stall = in_valid && !in_ready;
  assign issue_fire  = in_valid && in_ready;
  assign issue_u     = issue_fire ? sel : '0;

  // write-back broadcast
  always_comb begin
    bc_id  = '0;
    wb_reg = '0;
    for (int u = 0; u < NU; u++) begin
      if (wb_en[u]) begin
        bc_id  = unit_id(u);
        wb_reg = fi_a[u];
      end
    end
  end

  // producer lookup with same-cycle write-back taken as ready
  assign qj_raw = pend_id[in_src1];
  assign qk_raw = pend_id[in_src2];
  assign iss_qj = (qj_raw == bc_id) ? '0 : qj_raw;
  assign iss_qk = (qk_raw == bc_id) ? '0 : qk_raw;

  // WAR check: no other unit holds an unread ready copy of our destination
  always_comb begin
    war_ok = '1;
    for (int u = 0; u < NU; u++) begin
      for (int f = 0; f < NU; f++) begin
        if (f != u && ((fj_a[f] == fi_a[u] && rj_a[f]) || (fk_a[f] == fi_a[u] && rk_a[f])))
          war_ok[u] = 1'b0;
      end
    end
  end

  hzb_wb_arb #(.N(NU)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (wb_req & war_ok),
    .grant (wb_en)
  );

  hzb_regtab #(.NREG(NREG), .RW(RW)) u_regtab (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .set_id  (sel_id),
    .clr_en  (|wb_en),
    .clr_reg (wb_reg),
    .clr_id  (bc_id),
    .pend_id (pend_id)
  );

  for (genvar g = 0; g < NU; g++) begin : g_unit
    localparam int LU = (UNIT_CLS[g] == CLS_ADD) ? LAT_ADD :
                        (UNIT_CLS[g] == CLS_MUL) ? LAT_MUL : LAT_DIV;
    hzb_unit #(.LAT(LU), .RW(RW), .CW(CW)) u_fu (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue_u[g]),
      .iss_fi   (in_dst),
      .iss_fj   (in_src1),
      .iss_fk   (in_src2),
      .iss_qj   (iss_qj),
      .iss_qk   (iss_qk),
      .bc_id    (bc_id),
      .wb_grant (wb_en[g]),
      .busy     (fu_busy[g]),
      .fi       (fi_a[g]),
      .fj       (fj_a[g]),
      .fk       (fk_a[g]),
      .rj       (rj_a[g]),
      .rk       (rk_a[g]),
      .rd_grant (rd_grant[g]),
      .ex_done  (ex_done[g]),
      .wb_req   (wb_req[g])
    );
  end

  for (genvar r = 0; r < NREG; r++) begin : g_pend
    assign reg_pend[r] = (pend_id[r] != '0);
  end

  AST_ACCEPT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_u));  // R2
endmodule

// File: tb/fpu_hazard_board_test.sv
module fpu_hazard_board_test;
  localparam int CLK_P = 10;
  localparam int Q     = CLK_P / 4;
  localparam int LA = 2, LM = 4, LD = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready, issue_stall;
  logic [1:0] in_cls = 2'd0;
  logic [2:0] in_dst = 3'd0, in_src1 = 3'd0, in_src2 = 3'd0;
  logic [3:0] rd_grant, ex_done, wb_en, fu_busy;
  logic [7:0] reg_pend;

  int cyc = 0, errors = 0, checks = 0;
  int rd_at [4];
  int done_at [4];
  int wb_at [4];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpu_hazard_board #(.NREG(8), .LAT_ADD(LA), .LAT_MUL(LM), .LAT_DIV(LD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_stall(issue_stall), .rd_grant(rd_grant), .ex_done(ex_done),
    .wb_en(wb_en), .fu_busy(fu_busy), .reg_pend(reg_pend)
  );

  typedef struct packed {
    logic [1:0] cls;
    logic [2:0] dst, s1, s2;
    logic [1:0] unit;
    logic [7:0] lat;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd0, 3'd1, 3'd2, 3'd3, 2'd0, 8'(LA)},
    '{2'd1, 3'd2, 3'd4, 3'd5, 2'd1, 8'(LM)},
    '{2'd2, 3'd3, 3'd0, 3'd1, 2'd3, 8'(LD)},
    '{2'd0, 3'd7, 3'd7, 3'd7, 2'd0, 8'(LA)}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // event monitor, sampling a quarter period after the falling edge
  always begin
    @(negedge clk);
    #Q;
    for (int u = 0; u < 4; u++) begin
      if (rd_grant[u]) rd_at[u] = cyc;
      if (ex_done[u])  done_at[u] = cyc;
      if (wb_en[u])    wb_at[u] = cyc;
    end
    if (rst_n && $countones(wb_en) > 1) begin
      errors++;
      $display("FAIL R9: actual=%0d expected=1 write-backs in one cycle", $countones(wb_en));
    end
  end

  // starts and ends at a falling edge
  task automatic issue(input logic [1:0] c, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b, output int at, output bit stalled);
    int n = 0;
    stalled = 1'b0;
    in_valid = 1'b1; in_cls = c; in_dst = d; in_src1 = a; in_src2 = b;
    #Q;
    while (!in_ready && n < 300) begin
      stalled = 1'b1;
      @(negedge clk); #Q; n++;
    end
    at = cyc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int i0, t1, t2, t3;
    bit s;
    for (int u = 0; u < 4; u++) begin rd_at[u] = -1; done_at[u] = -1; wb_at[u] = -1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    in_valid = 1'b1; in_cls = 2'd0; in_dst = 3'd6;
    #Q;
    check("R1 busy", fu_busy, 0);
    check("R1 pend", reg_pend, 0);
    check("R1 events", {rd_grant, ex_done, wb_en}, 0);
    check("R1 ready", in_ready, 1);
    in_valid = 1'b0;
    @(negedge clk);

    // table walk: isolated instructions
    for (int k = 0; k < 4; k++) begin
      issue(VECS[k].cls, VECS[k].dst, VECS[k].s1, VECS[k].s2, i0, s);
      #Q;
      check("R11 busy", fu_busy[VECS[k].unit], 1);
      check("R11 pend", reg_pend[VECS[k].dst], 1);
      wait_until(i0 + int'(VECS[k].lat) + 4);
      check("R2 R5 read", rd_at[VECS[k].unit], i0 + 1);
      check("R6 done", done_at[VECS[k].unit], i0 + 1 + int'(VECS[k].lat));
      check("R7 wb", wb_at[VECS[k].unit], i0 + 2 + int'(VECS[k].lat));
      check("R7 R11 free", {fu_busy, reg_pend}, 0);
    end
    settle();

    // R2 R3: two multipliers, third waits for a free one
    issue(2'd1, 3'd1, 3'd0, 3'd0, i0, s);
    issue(2'd1, 3'd2, 3'd0, 3'd0, t1, s);
    issue(2'd1, 3'd3, 3'd0, 3'd0, t2, s);
    check("R2 second mul unit2", rd_at[2], i0 + 2);
    check("R3 stalled", s, 1);
    check("R3 issue after free", t2, i0 + 7);
    settle();

    // R2: class 3 never accepted
    in_valid = 1'b1; in_cls = 2'd3; in_dst = 3'd5;
    #Q;
    check("R2 class3 ready", in_ready, 0);
    check("R2 class3 stall", issue_stall, 1);
    repeat (3) @(negedge clk);
    in_valid = 1'b0; #Q;
    check("R2 class3 ignored", {fu_busy, reg_pend}, 0);
    @(negedge clk);

    // R4: WAW hold
    issue(2'd2, 3'd4, 3'd0, 3'd0, i0, s);
    issue(2'd1, 3'd4, 3'd1, 3'd1, t1, s);
    check("R4 stalled", s, 1);
    check("R4 issue after wb", t1, i0 + 6);
    settle();

    // R5: no forwarding
    issue(2'd0, 3'd1, 3'd0, 3'd0, i0, s);
    issue(2'd1, 3'd2, 3'd1, 3'd0, t1, s);
    wait_until(i0 + 8);
    check("R5 dependent read", rd_at[1], i0 + 5);
    settle();

    // R10: issue in producer's write-back cycle
    issue(2'd2, 3'd5, 3'd0, 3'd0, i0, s);
    wait_until(i0 + 5);
    issue(2'd0, 3'd6, 3'd5, 3'd0, t1, s);
    check("R10 issue cycle", t1, i0 + 5);
    wait_until(i0 + 8);
    check("R10 read", rd_at[0], i0 + 6);
    settle();

    // R8: WAR hold
    issue(2'd1, 3'd4, 3'd1, 3'd1, i0, s);
    issue(2'd0, 3'd5, 3'd6, 3'd4, t1, s);
    issue(2'd2, 3'd6, 3'd2, 3'd3, t2, s);
    wait_until(i0 + 12);
    check("R8 div done", done_at[3], i0 + 6);
    check("R8 add read", rd_at[0], i0 + 7);
    check("R8 div wb held", wb_at[3], i0 + 8);
    settle();

    // R9: simultaneous write-back
    issue(2'd2, 3'd1, 3'd0, 3'd0, i0, s);
    issue(2'd0, 3'd2, 3'd0, 3'd0, t3, s);
    wait_until(i0 + 9);
    check("R9 low index first", wb_at[0], i0 + 5);
    check("R9 retry", wb_at[3], i0 + 6);
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule